// File: doc/BRIEF.md
# Shared Address Bus Arbiter with Snoop-Retry Return

This block decides which of several bus masters owns a shared address bus. One master is a CPU with a write-back data cache. Each master raises its own request line. The arbiter drives exactly one grant line high at all times. The grant holder opens an address tenure with a start strobe. The tenure closes when the addressed target returns an acknowledge.

If the CPU snoops a tenure from another master and finds a modified line, it raises the retry input together with the acknowledge that closes that tenure. The arbiter then hands the bus to the CPU at once, so that the CPU can write the line back. It records which master was retried. When the CPU's copyback tenure closes, the bus goes straight back to the retried master, ahead of every other requester. Ordinary arbitration then resumes.

Outside retry handling, requesters are served in round-robin order. When nobody requests, the grant rests on a park master named by a configuration input. That master may start a tenure without requesting first.

Top module: `abArb`

## Requirements
- R1: Exactly one bit of `grantVec` is high in every cycle; bit i grants master i, and reset leaves master 0 granted.
- R2: An address tenure is open from the cycle after `tsIn` is sampled until `aackIn` is sampled. The grant changes only at the clock edge that samples `aackIn`, or at an edge where no tenure is open and `tsIn` is low (an idle cycle).
- R3: When `aackIn` and `retryIn` are sampled together while a master other than the CPU (index `CPU_ID`) holds the grant, the next grant goes to the CPU, whatever the request lines show.
- R4: From that retry until the CPU's own tenure ends, the CPU keeps the grant through idle cycles, and all other requests are ignored.
- R5: When `aackIn` is sampled while the CPU holds the grant in copyback, the next grant goes to the retried master, ahead of any other requester.
- R6: `retryIn` has no effect when it is sampled without `aackIn`, or when the CPU itself holds the grant outside copyback.
- R7: At a normal decision point with at least one request, the grant goes to the first requesting master after the pointer, counting upward with wrap-around. The pointer is the index of the last master given the grant by round-robin, retry or return. Parking leaves it unchanged. Reset sets it to N-1.
- R8: In an idle cycle with every request low, the next grant goes to the master whose index is on `parkSel`.
- R9: A master holding the grant may start a tenure with `tsIn` while its request is low, and it keeps the grant until that tenure's `aackIn`.
- R10: In an idle cycle where the current holder's request is high, the holder keeps the grant, even if other masters are requesting.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqVec | input | N | Request line per master, bit i is master i |
| tsIn | input | 1 | Tenure start strobe from the grant holder |
| aackIn | input | 1 | Address acknowledge, closes the open tenure |
| retryIn | input | 1 | CPU retry, valid with `aackIn` |
| parkSel | input | $clog2(N) | Index of the park master |
| grantVec | output | N | One-hot grant, bit i is master i |

## Verification
Round-robin is driven with every master requesting, and then with a sparse set whose pointer wraps past the top index. This shows whether the pointer advances past the last winner or restarts from a fixed master. In the retry pattern, other masters request while the CPU holds the grant in copyback, and again at the moment the copyback closes. This separates a true return to the retried master from an ordinary round-robin pick. Retry is also raised without an acknowledge, and raised while the CPU owns the bus, to confirm that it is ignored there. In an idle bus, a start is given with no request behind it, to show that a parked master holds the grant for its whole tenure.

// File: rtl/abArbPkg.sv
package abArbPkg;

  typedef enum logic [2:0] {
    SRC_HOLD,
    SRC_RR,
    SRC_CPU,
    SRC_RET,
    SRC_PARK
  } grantSrc_e;

  typedef struct packed {
    grantSrc_e src;
    logic      latchRet;
  } arbStrobe_t;

endpackage

// File: rtl/abArbCtrl.sv
module abArbCtrl
  import abArbPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       tsIn,
  input  logic       aackIn,
  input  logic       retryIn,
  input  logic       anyReq,
  input  logic       ownerReq,
  input  logic       ownerIsCpu,
  output arbStrobe_t stb,
  output logic       busy,
  output logic       cbActive
);

  logic busyQ;
  logic cbQ;
  logic cbD;
  logic idleNow;

  assign idleNow = !busyQ && !tsIn;

  always_comb begin
    stb      = '{src: SRC_HOLD, latchRet: 1'b0};
    cbD      = cbQ;
    if (cbQ) begin
      if (aackIn && ownerIsCpu) begin
        stb.src = SRC_RET;
        cbD     = 1'b0;
      end
    end else if (aackIn && retryIn && !ownerIsCpu) begin
      stb.src      = SRC_CPU;
      stb.latchRet = 1'b1;
      cbD          = 1'b1;
    end else if (aackIn || idleNow) begin
      if (idleNow && ownerReq) begin
        stb.src = SRC_HOLD;
      end else if (anyReq) begin
        stb.src = SRC_RR;
      end else begin
        stb.src = SRC_PARK;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyQ <= 1'b0;
      cbQ   <= 1'b0;
    end else begin
      cbQ <= cbD;
      if (aackIn) begin
        busyQ <= 1'b0;
      end else if (tsIn) begin
        busyQ <= 1'b1;
      end
    end
  end

  assign busy     = busyQ;
  assign cbActive = cbQ;

  AST_RET_LEAVES_CB: assert property (@(posedge clk) disable iff (!rstN)
    (stb.src == SRC_RET) |=> !cbQ); // R5

endmodule

// File: rtl/abArbDatapath.sv
module abArbDatapath
  import abArbPkg::*;
#(
  parameter int N      = 4,
  parameter int CPU_ID = 0,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [N-1:0]     reqVec,
  input  logic [IDX_W-1:0] parkSel,
  input  arbStrobe_t       stb,
  output logic [N-1:0]     grantVec,
  output logic             anyReq,
  output logic             ownerReq,
  output logic             ownerIsCpu
);

  logic [N-1:0]     grantQ;
  logic [IDX_W-1:0] ownerIdx;
  logic [IDX_W-1:0] ptrQ;
  logic [IDX_W-1:0] retQ;
  logic [IDX_W-1:0] rrIdx;
  logic [IDX_W-1:0] nextIdx;
  logic             rrHit;

  always_comb begin
    ownerIdx = '0;
    for (int i = 0; i < N; i++) begin
      if (grantQ[i]) ownerIdx = IDX_W'(i);
    end
  end

  assign anyReq     = |reqVec;
  assign ownerReq   = reqVec[ownerIdx];
  assign ownerIsCpu = grantQ[CPU_ID];

  always_comb begin
    rrIdx = ptrQ;
    rrHit = 1'b0;
    for (int k = 1; k <= N; k++) begin
      int cand;
      cand = (int'(ptrQ) + k) % N;
      if (!rrHit && reqVec[cand]) begin
        rrHit = 1'b1;
        rrIdx = IDX_W'(cand);
      end
    end
  end

  always_comb begin
    case (stb.src)
      SRC_RR:   nextIdx = rrIdx;
      SRC_CPU:  nextIdx = IDX_W'(CPU_ID);
      SRC_RET:  nextIdx = retQ;
      SRC_PARK: nextIdx = parkSel;
      default:  nextIdx = ownerIdx;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      grantQ <= N'(1);
      ptrQ   <= IDX_W'(N - 1);
      retQ   <= '0;
    end else begin
      if (stb.src != SRC_HOLD) begin
        grantQ <= N'(1) << nextIdx;
      end
      if (stb.src == SRC_RR || stb.src == SRC_CPU || stb.src == SRC_RET) begin
        ptrQ <= nextIdx;
      end
      if (stb.latchRet) begin
        retQ <= ownerIdx;
      end
    end
  end

  assign grantVec = grantQ;

  AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $countones(grantVec) == 1); // R1

  AST_PARK_TARGET: assert property (@(posedge clk) disable iff (!rstN)
    (stb.src == SRC_PARK) |=> grantVec[$past(parkSel)]); // R8

  AST_RETURN_TARGET: assert property (@(posedge clk) disable iff (!rstN)
    (stb.src == SRC_RET) |=> grantVec[$past(retQ)]); // R5

  AST_RR_PICKS_REQUESTER: assert property (@(posedge clk) disable iff (!rstN)
    (stb.src == SRC_RR) |=> |(grantVec & $past(reqVec))); // R7

endmodule

// File: rtl/abArb.sv
module abArb
  import abArbPkg::*;
#(
  parameter int N      = 4,
  parameter int CPU_ID = 0,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [N-1:0]     reqVec,
  input  logic             tsIn,
  input  logic             aackIn,
  input  logic             retryIn,
  input  logic [IDX_W-1:0] parkSel,
  output logic [N-1:0]     grantVec
);

  arbStrobe_t stb;
  logic       anyReq;
  logic       ownerReq;
  logic       ownerIsCpu;
  logic       busy;
  logic       cbActive;

  abArbCtrl i_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .tsIn       (tsIn),
    .aackIn     (aackIn),
    .retryIn    (retryIn),
    .anyReq     (anyReq),
    .ownerReq   (ownerReq),
    .ownerIsCpu (ownerIsCpu),
    .stb        (stb),
    .busy       (busy),
    .cbActive   (cbActive)
  );

  abArbDatapath #(.N(N), .CPU_ID(CPU_ID)) i_dp (
    .clk        (clk),
    .rstN       (rstN),
    .reqVec     (reqVec),
    .parkSel    (parkSel),
    .stb        (stb),
    .grantVec   (grantVec),
    .anyReq     (anyReq),
    .ownerReq   (ownerReq),
    .ownerIsCpu (ownerIsCpu)
  );

  AST_HOLD_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !aackIn) |=> $stable(grantVec)); // R2

  AST_RETRY_GRANTS_CPU: assert property (@(posedge clk) disable iff (!rstN)
    (aackIn && retryIn && !cbActive && !grantVec[CPU_ID]) |=> grantVec[CPU_ID]); // R3

  AST_CB_KEEPS_CPU: assert property (@(posedge clk) disable iff (!rstN)
    (cbActive && !(aackIn && grantVec[CPU_ID])) |=> grantVec[CPU_ID]); // R4

endmodule

// File: tb/test_abArb.sv
`timescale 1ns/1ps
module test_abArb;

  localparam int N      = 4;
  localparam int CPU_ID = 0;
  localparam int IDX_W  = 2;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic [N-1:0]     reqVec = '0;
  logic             tsIn = 1'b0;
  logic             aackIn = 1'b0;
  logic             retryIn = 1'b0;
  logic [IDX_W-1:0] parkSel = '0;
  logic [N-1:0]     grantVec;

  int errors = 0;
  int checks = 0;

  typedef struct {
    logic [N-1:0] exp;
    string        tag;
  } expItem_t;

  expItem_t sbQ[$];

  // reference state
  int  mGrant = 0;
  int  mPtr   = N - 1;
  int  mRet   = 0;
  bit  mCb    = 0;
  bit  mBusy  = 0;

  always #4 clk = ~clk;

  abArb #(.N(N), .CPU_ID(CPU_ID)) i_abArb (
    .clk      (clk),
    .rstN     (rstN),
    .reqVec   (reqVec),
    .tsIn     (tsIn),
    .aackIn   (aackIn),
    .retryIn  (retryIn),
    .parkSel  (parkSel),
    .grantVec (grantVec)
  );

  task automatic modelStep(logic [N-1:0] r, logic ts, logic ak, logic rt, int pk);
    bit idle;
    int nextG;
    idle  = !mBusy && !ts;
    nextG = mGrant;
    if (mCb) begin
      if (ak && mGrant == CPU_ID) begin
        nextG = mRet; mPtr = mRet; mCb = 0;
      end
    end else if (ak && rt && mGrant != CPU_ID) begin
      mRet = mGrant; nextG = CPU_ID; mPtr = CPU_ID; mCb = 1;
    end else if (ak || idle) begin
      if (idle && r[mGrant]) begin
        nextG = mGrant;
      end else if (r != '0) begin
        for (int k = 1; k <= N; k++) begin
          int c;
          c = (mPtr + k) % N;
          if (r[c]) begin nextG = c; break; end
        end
        mPtr = nextG;
      end else begin
        nextG = pk;
      end
    end
    if (ak) mBusy = 0;
    else if (ts) mBusy = 1;
    mGrant = nextG;
  endtask

  task automatic drive(logic [N-1:0] r, logic ts, logic ak, logic rt, int pk, string tag);
    expItem_t it;
    @(negedge clk);
    reqVec  = r;
    tsIn    = ts;
    aackIn  = ak;
    retryIn = rt;
    parkSel = IDX_W'(pk);
    modelStep(r, ts, ak, rt, pk);
    it.exp = N'(1) << mGrant;
    it.tag = tag;
    sbQ.push_back(it);
  endtask

  // monitor: compares each grant one step after the edge that produced it
  always @(posedge clk) begin
    #1;
    if (rstN && sbQ.size() > 0) begin
      expItem_t it;
      it = sbQ.pop_front();
      checks++;
      if (grantVec !== it.exp) begin
        errors++;
        $display("FAIL %s: grant actual=%b expected=%b", it.tag, grantVec, it.exp);
      end
    end
  end

  initial begin
    #(200000 * 8);
    errors++;
    $display("FAIL watchdog: run hung, actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    checks++;
    if (grantVec !== 4'b0001) begin
      errors++;
      $display("FAIL R1: reset grant actual=%b expected=%b", grantVec, 4'b0001);
    end

    // R8: idle with no requests parks on master 2
    drive(4'b0000, 0, 0, 0, 2, "R8");
    drive(4'b0000, 0, 0, 0, 2, "R8");

    // R9: parked master starts without request; R2: held while busy
    drive(4'b0000, 1, 0, 0, 2, "R9");
    drive(4'b1011, 0, 0, 0, 2, "R2");
    drive(4'b1011, 0, 0, 0, 2, "R2");
    drive(4'b1011, 0, 1, 0, 2, "R7");

    // R10: idle holder with request keeps grant
    drive(4'b0111, 0, 0, 0, 2, "R10");
    drive(4'b0111, 0, 0, 0, 2, "R10");

    // R7: round-robin with wrap
    drive(4'b1110, 1, 0, 0, 2, "R2");
    drive(4'b1110, 0, 1, 0, 2, "R7");
    drive(4'b1110, 1, 0, 0, 2, "R2");
    drive(4'b1110, 0, 1, 0, 2, "R7");
    drive(4'b1110, 1, 0, 0, 2, "R2");
    drive(4'b1110, 0, 1, 0, 2, "R7");
    drive(4'b1110, 1, 0, 0, 2, "R2");
    drive(4'b1110, 0, 1, 0, 2, "R7");

    // R3/R4/R5: retry of master 1, copyback, return
    drive(4'b1111, 1, 0, 0, 2, "R2");
    drive(4'b1111, 0, 1, 1, 2, "R3");
    drive(4'b1110, 0, 0, 0, 2, "R4");
    drive(4'b0000, 0, 0, 0, 2, "R4");
    drive(4'b1110, 1, 0, 0, 2, "R4");
    drive(4'b1100, 0, 1, 0, 2, "R5");

    // R6: retry without acknowledge, and retry while the CPU owns
    drive(4'b1101, 1, 0, 0, 2, "R2");
    drive(4'b1101, 0, 0, 1, 2, "R6");
    drive(4'b1101, 0, 1, 0, 2, "R7");
    drive(4'b0001, 1, 0, 0, 2, "R2");
    drive(4'b0001, 0, 1, 0, 2, "R7");
    drive(4'b1000, 1, 0, 0, 2, "R2");
    drive(4'b1000, 0, 1, 1, 2, "R6");
    drive(4'b0000, 0, 0, 0, 1, "R8");

    repeat (3) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule